// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block decides when a processor core stops its clock for a light sleep and when it starts it again. There are two ways in. The core can issue a wait-for-interrupt request. Alternatively, the core can return from an interrupt handler while the sleep-on-exit bit is set. Either way, entry needs the deep-sleep select bit to be clear and no interrupt to be pending. A pending interrupt wakes the core.

At entry, the controller picks one of two variants. It uses low-power sleep when software asks for the low-power regulator and the core-voltage indication reports range 2. In every other case it uses ordinary sleep. Software can also ask for the flash to be powered down for the duration of the sleep. When that option was taken, waking holds the core clock gated for a programmable number of cycles after the power-down request is released, so that the flash is ready before the core resumes.

The block drives no I/O or memory-disable outputs, so pin states and RAM contents are untouched.

Top module: `lps_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (run) and `core_clk_gate`, `flash_pd_req` and `reg_lp_out` are all 0.
- R2: In run, a `wfi_req` sampled with `deep_sel`=0 and `irq_pend`=0 makes `mode` read 1 or 2 after that clock edge, with `core_clk_gate`=1.
- R3: In run, `isr_ret` enters sleep only when `exit_sleep_en`=1 (with `deep_sel`=0 and `irq_pend`=0). With `exit_sleep_en`=0 the block stays in run.
- R4: With `deep_sel`=1, no entry request has an effect: `mode` stays 0.
- R5: If `irq_pend`=1 in the same cycle as an entry request, the request is ignored and `mode` stays 0.
- R6: Entry goes to low-power sleep (`mode`=2, `reg_lp_out`=1) only when `reg_lp_en`=1 and `vcore_range`=2'd2. Otherwise it goes to ordinary sleep (`mode`=1, `reg_lp_out`=0).
- R7: `flash_pd_req` is 1 during sleep exactly when `flash_off_en` was 1 in the entry cycle.
- R8: In sleep without flash power-down, `irq_pend`=1 returns `mode` to 0 with `core_clk_gate`=0 at the next edge, with no added latency.
- R9: In sleep with flash power-down and `wake_hold`=N>0, `irq_pend` gives `mode`=3 for exactly N cycles, with `core_clk_gate`=1 and `flash_pd_req`=0. `mode` then returns to 0. Entry requests during this window are ignored.
- R10: With flash power-down and `wake_hold`=0, waking goes straight to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| isr_ret | input | 1 | One-cycle strobe on return from an interrupt handler |
| deep_sel | input | 1 | Deep-sleep select; 1 blocks this light sleep |
| exit_sleep_en | input | 1 | Sleep-on-exit enable |
| flash_off_en | input | 1 | Power down flash while asleep |
| reg_lp_en | input | 1 | Software request for low-power regulator |
| vcore_range | input | 2 | Core voltage range indication (2'd2 = range 2) |
| irq_pend | input | 1 | An interrupt is pending |
| wake_hold | input | 8 | Cycles the clock stays gated after flash wake |
| core_clk_gate | output | 1 | 1 = core clock stopped |
| flash_pd_req | output | 1 | Flash power-down request |
| reg_lp_out | output | 1 | Regulator low-power enable |
| mode | output | 2 | 0 run, 1 sleep, 2 low-power sleep, 3 waking |

## Verification
The hardest situation to reach is a request that arrives while the controller is waking. To get there, the flash power-down must be latched at entry, a non-zero hold count must be present at the wake edge, and a new request must then land inside the hold window. The bench enters sleep with `flash_off_en` set and `wake_hold`=3, then raises `irq_pend`. It raises `wfi_req` during the first waking cycle and counts the cycles in which `mode` reads 3. It expects exactly three such cycles, followed by run. The direct-wake and zero-hold paths serve as contrast cases, showing that waking costs no extra cycle unless the flash was powered down.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_LPSLEEP = 2'd2,
    MODE_WAKE    = 2'd3
  } lps_mode_e;
endpackage

// File: rtl/lps_entry_qual.sv
// Combinational qualification of sleep entry and variant choice.
module lps_entry_qual #(
  parameter int RANGE_W  = 2,
  parameter int LP_RANGE = 2
) (
  input  logic               wfi_req,
  input  logic               isr_ret,
  input  logic               deep_sel,
  input  logic               exit_sleep_en,
  input  logic               irq_pend,
  input  logic               reg_lp_en,
  input  logic [RANGE_W-1:0] vcore_range,
  output logic               go_sleep,
  output logic               use_lp
);
  localparam logic [RANGE_W-1:0] LpRangeCode = RANGE_W'(LP_RANGE);

  logic any_req;

  always_comb begin
    any_req  = wfi_req | (isr_ret & exit_sleep_en);
    go_sleep = any_req & ~deep_sel & ~irq_pend;
    use_lp   = reg_lp_en & (vcore_range == LpRangeCode);
  end
endmodule

// File: rtl/lps_wake_timer.sv
// Down counter that times the gated-clock window after a flash wake.
module lps_wake_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  input  logic              tick,
  output logic              last
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load | (tick & (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign last = (cnt_q == HOLD_W'(1));
endmodule

// File: rtl/lps_out_drive.sv
// Moore decode of controller state into power-control outputs.
module lps_out_drive
  import lps_pkg::*;
(
  input  lps_mode_e   state,
  input  logic        fpd_active,
  output logic        core_clk_gate,
  output logic        flash_pd_req,
  output logic        reg_lp_out,
  output logic [1:0]  mode
);
  logic asleep;

  always_comb begin
    asleep        = (state == MODE_SLEEP) || (state == MODE_LPSLEEP);
    core_clk_gate = asleep || (state == MODE_WAKE);
    flash_pd_req  = asleep && fpd_active;
    reg_lp_out    = (state == MODE_LPSLEEP);
    mode          = state;
  end
endmodule

// File: rtl/lps_ctrl.sv
// Low-power sleep mode controller top.
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int HOLD_W   = 8,
  parameter int RANGE_W  = 2,
  parameter int LP_RANGE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_req,
  input  logic               isr_ret,
  input  logic               deep_sel,
  input  logic               exit_sleep_en,
  input  logic               flash_off_en,
  input  logic               reg_lp_en,
  input  logic [RANGE_W-1:0] vcore_range,
  input  logic               irq_pend,
  input  logic [HOLD_W-1:0]  wake_hold,
  output logic               core_clk_gate,
  output logic               flash_pd_req,
  output logic               reg_lp_out,
  output logic [1:0]         mode
);
  lps_mode_e state_q, state_d;
  logic      fpd_q, fpd_d;
  logic      go_sleep, use_lp;
  logic      tmr_load, tmr_tick, tmr_last;

  lps_entry_qual #(.RANGE_W(RANGE_W), .LP_RANGE(LP_RANGE)) u_qual (
    .wfi_req      (wfi_req),
    .isr_ret      (isr_ret),
    .deep_sel     (deep_sel),
    .exit_sleep_en(exit_sleep_en),
    .irq_pend     (irq_pend),
    .reg_lp_en    (reg_lp_en),
    .vcore_range  (vcore_range),
    .go_sleep     (go_sleep),
    .use_lp       (use_lp)
  );

  lps_wake_timer #(.HOLD_W(HOLD_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(wake_hold),
    .tick    (tmr_tick),
    .last    (tmr_last)
  );

  // Next-state process
  always_comb begin
    state_d  = state_q;
    fpd_d    = fpd_q;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    unique case (state_q)
      MODE_RUN: begin
        if (go_sleep) begin
          state_d = use_lp ? MODE_LPSLEEP : MODE_SLEEP;
          fpd_d   = flash_off_en;
        end
      end
      MODE_SLEEP, MODE_LPSLEEP: begin
        if (irq_pend) begin
          fpd_d = 1'b0;
          if (fpd_q && (wake_hold != '0)) begin
            state_d  = MODE_WAKE;
            tmr_load = 1'b1;
          end else begin
            state_d = MODE_RUN;
          end
        end
      end
      MODE_WAKE: begin
        tmr_tick = 1'b1;
        if (tmr_last)
          state_d = MODE_RUN;
      end
      default: state_d = MODE_RUN;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_RUN;
      fpd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fpd_q   <= fpd_d;
    end
  end

  lps_out_drive u_out (
    .state        (state_q),
    .fpd_active   (fpd_q),
    .core_clk_gate(core_clk_gate),
    .flash_pd_req (flash_pd_req),
    .reg_lp_out   (reg_lp_out),
    .mode         (mode)
  );
endmodule

// File: rtl/lps_ctrl_chk.sv
// Property checker for lps_ctrl, attached by bind.
module lps_ctrl_chk #(
  parameter int HOLD_W  = 8,
  parameter int RANGE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wfi_req,
  input logic               isr_ret,
  input logic               deep_sel,
  input logic               exit_sleep_en,
  input logic               flash_off_en,
  input logic [RANGE_W-1:0] vcore_range,
  input logic               irq_pend,
  input logic [HOLD_W-1:0]  wake_hold,
  input logic               core_clk_gate,
  input logic               flash_pd_req,
  input logic               reg_lp_out,
  input logic [1:0]         mode
);
  // R2
  wfi_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && wfi_req && !deep_sel && !irq_pend)
      |=> ((mode == 2'd1 || mode == 2'd2) && core_clk_gate));

  // R3
  onexit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && isr_ret && !exit_sleep_en && !wfi_req) |=> (mode == 2'd0));

  // R4
  deep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && deep_sel) |=> (mode == 2'd0));

  // R5
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && irq_pend) |=> (mode == 2'd0));

  // R6
  range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && vcore_range != RANGE_W'(2)) |=> (mode != 2'd2));

  // R6
  lp_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !reg_lp_out);

  // R7
  flash_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && wfi_req && !deep_sel && !irq_pend && !flash_off_en)
      |=> !flash_pd_req);

  // R8
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1 || mode == 2'd2) && irq_pend) |=> (mode == 2'd0 || mode == 2'd3));

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (core_clk_gate && !flash_pd_req && !reg_lp_out));

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1 || mode == 2'd2) && irq_pend && wake_hold == '0) |=> (mode == 2'd0));
endmodule

bind lps_ctrl lps_ctrl_chk #(.HOLD_W(HOLD_W), .RANGE_W(RANGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wfi_req      (wfi_req),
  .isr_ret      (isr_ret),
  .deep_sel     (deep_sel),
  .exit_sleep_en(exit_sleep_en),
  .flash_off_en (flash_off_en),
  .vcore_range  (vcore_range),
  .irq_pend     (irq_pend),
  .wake_hold    (wake_hold),
  .core_clk_gate(core_clk_gate),
  .flash_pd_req (flash_pd_req),
  .reg_lp_out   (reg_lp_out),
  .mode         (mode)
);

// File: tb/sim_lps_ctrl.sv
`timescale 1ns/1ps
module sim_lps_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_req = 1'b0, isr_ret = 1'b0, deep_sel = 1'b0, exit_sleep_en = 1'b0;
  logic       flash_off_en = 1'b0, reg_lp_en = 1'b0, irq_pend = 1'b0;
  logic [1:0] vcore_range = 2'd2;
  logic [7:0] wake_hold = 8'd0;
  logic       core_clk_gate, flash_pd_req, reg_lp_out;
  logic [1:0] mode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lps_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .isr_ret(isr_ret),
    .deep_sel(deep_sel), .exit_sleep_en(exit_sleep_en), .flash_off_en(flash_off_en),
    .reg_lp_en(reg_lp_en), .vcore_range(vcore_range), .irq_pend(irq_pend),
    .wake_hold(wake_hold), .core_clk_gate(core_clk_gate), .flash_pd_req(flash_pd_req),
    .reg_lp_out(reg_lp_out), .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge; inputs changed at negedge, outputs sampled at next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wfi_req = 0; isr_ret = 0; irq_pend = 0; deep_sel = 0;
  endtask

  task automatic wake_plain();
    irq_pend = 1; step(); irq_pend = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 clk_gate", core_clk_gate, 0);
    chk("R1 flash_pd", flash_pd_req, 0);
    chk("R1 reg_lp", reg_lp_out, 0);
  endtask

  task automatic t_wfi_direct();
    flash_off_en = 0; reg_lp_en = 0;
    wfi_req = 1; step(); wfi_req = 0;
    chk("R2 mode", mode, 1);
    chk("R2 clk_gate", core_clk_gate, 1);
    chk("R7 flash_pd off", flash_pd_req, 0);
    step();
    chk("R2 stays asleep", mode, 1);
    irq_pend = 1; step(); irq_pend = 0;
    chk("R8 mode", mode, 0);
    chk("R8 clk_gate", core_clk_gate, 0);
  endtask

  task automatic t_on_exit();
    exit_sleep_en = 0; isr_ret = 1; step(); isr_ret = 0;
    chk("R3 no exit-sleep", mode, 0);
    exit_sleep_en = 1; isr_ret = 1; step(); isr_ret = 0;
    chk("R3 exit-sleep", mode, 1);
    wake_plain();
    chk("R3 woke", mode, 0);
    exit_sleep_en = 0;
  endtask

  task automatic t_deep_block();
    deep_sel = 1; wfi_req = 1; step();
    chk("R4 wfi blocked", mode, 0);
    exit_sleep_en = 1; wfi_req = 0; isr_ret = 1; step();
    chk("R4 isr_ret blocked", mode, 0);
    chk("R4 clk_gate", core_clk_gate, 0);
    idle_inputs(); exit_sleep_en = 0;
  endtask

  task automatic t_pend_block();
    irq_pend = 1; wfi_req = 1; step();
    chk("R5 wfi ignored", mode, 0);
    wfi_req = 0; exit_sleep_en = 1; isr_ret = 1; step();
    chk("R5 isr_ret ignored", mode, 0);
    idle_inputs(); exit_sleep_en = 0;
  endtask

  task automatic t_lp_variant();
    reg_lp_en = 1; vcore_range = 2'd2;
    wfi_req = 1; step(); wfi_req = 0;
    chk("R6 lp mode", mode, 2);
    chk("R6 reg_lp on", reg_lp_out, 1);
    wake_plain();
    chk("R6 lp woke", mode, 0);
    chk("R6 reg_lp off after wake", reg_lp_out, 0);
    vcore_range = 2'd1;
    wfi_req = 1; step(); wfi_req = 0;
    chk("R6 range1 ordinary", mode, 1);
    chk("R6 range1 reg_lp", reg_lp_out, 0);
    wake_plain();
    reg_lp_en = 0; vcore_range = 2'd2;
    wfi_req = 1; step(); wfi_req = 0;
    chk("R6 no lp request", mode, 1);
    chk("R6 no lp reg", reg_lp_out, 0);
    wake_plain();
  endtask

  task automatic t_flash_wake();
    int n;
    flash_off_en = 1; wake_hold = 8'd3;
    wfi_req = 1; step(); wfi_req = 0;
    flash_off_en = 0;  // change after entry must not matter
    chk("R7 flash_pd on", flash_pd_req, 1);
    step();
    chk("R7 flash_pd held", flash_pd_req, 1);
    irq_pend = 1; step(); irq_pend = 0;
    chk("R9 waking", mode, 3);
    chk("R9 clk gated", core_clk_gate, 1);
    chk("R9 flash released", flash_pd_req, 0);
    n = 1;
    wfi_req = 1;  // request during the wake window
    for (int i = 0; i < 10 && mode == 2'd3; i++) begin
      step();
      if (mode == 2'd3) n++;
    end
    wfi_req = 0;
    chk("R9 wake cycles", n, 3);
    chk("R9 back to run", mode, 0);
    chk("R9 clk running", core_clk_gate, 0);
  endtask

  task automatic t_zero_hold();
    flash_off_en = 1; wake_hold = 8'd0;
    wfi_req = 1; step(); wfi_req = 0;
    chk("R10 flash_pd on", flash_pd_req, 1);
    irq_pend = 1; step(); irq_pend = 0;
    chk("R10 direct run", mode, 0);
    chk("R10 clk running", core_clk_gate, 0);
    flash_off_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wfi_direct();
    t_on_exit();
    t_deep_block();
    t_pend_block();
    t_lp_variant();
    t_flash_wake();
    t_zero_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule